// File: doc/BRIEF.md
# Memory Address Generation Unit

This block forms the effective address of a load or store. Each cycle it may accept one operation made of a base register value, an index register value, the program counter, a displacement field with a width code, a scale code, an access size and a mode select. It sign-extends the displacement to the address width and shifts the index left by the scale code. It then adds the terms that the selected mode calls for and tests the resulting address against the access size.

The arithmetic is combinational. One register stage follows it, so the address, the misalignment flag and a valid strobe appear on the clock edge after the operation is offered. The block only raises the misalignment flag. Memory access, translation, protection and trap handling belong to the logic that consumes its outputs.

Top module: `addr_gen_unit`

## Requirements
- R1: While reset is asserted (active low), and after it is released until the first accepted operation, `out_valid`, `eff_addr` and `misaligned` are all zero.
- R2: An operation offered with `in_valid` high at a clock edge produces its results at that edge, and `out_valid` is high in the cycle that follows. `out_valid` is low after any edge where `in_valid` was low.
- R3: An edge where `in_valid` is low leaves `eff_addr` and `misaligned` unchanged, whatever the other inputs carry.
- R4: The displacement width code selects the sign-extended displacement. Code 0 uses bits 7:0, code 1 uses bits 15:0, and codes 2 and 3 use all 32 bits. Bits above the selected width have no effect.
- R5: Mode 0 (absolute) gives the sign-extended displacement.
- R6: Mode 1 (register indirect) gives the base value.
- R7: Mode 2 (base plus offset) gives base plus the sign-extended displacement.
- R8: Mode 3 (indexed) gives base plus index. The scale code and the displacement have no effect.
- R9: Mode 4 (scaled) gives base plus index shifted left by the scale code (0 to 3, a factor of 1, 2, 4 or 8) plus the sign-extended displacement.
- R10: Mode 5 (PC-relative) gives the program counter plus the sign-extended displacement.
- R11: Modes 6 and 7 are reserved and act as register indirect, giving the base value.
- R12: All address sums wrap modulo 2^32. There is no overflow indication.
- R13: The access size code gives 2^code bytes: 0 is byte, 1 is halfword, 2 is word and 3 is doubleword. `misaligned` is set when any of the low `code` bits of the computed address is one. A byte access never sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is offered this cycle |
| mode | input | 3 | Addressing mode select, 0 to 7 |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| pc | input | 32 | Program counter |
| disp | input | 32 | Raw displacement field |
| disp_sz | input | 2 | Displacement width code |
| scale | input | 2 | Index shift amount, 0 to 3 |
| acc_sz | input | 2 | Access size code (log2 of bytes) |
| out_valid | output | 1 | Results are valid this cycle |
| eff_addr | output | 32 | Effective address |
| misaligned | output | 1 | Address is not a multiple of the access size |

## Verification
The bench builds the unit with its default parameters: a 32-bit address and a 2-bit access size code, which allows accesses of up to eight bytes. With a 32-bit address, wrap-around past 2^32 can be reached with small offsets from an all-ones base. The 2-bit size code makes the doubleword case reachable, so the three-bit alignment test is exercised alongside the halfword and word tests. All four scale shifts and all three displacement widths are reached. The displacement patterns set the sign bit and carry non-zero bits above the selected width.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_ABS    = 3'd0,
    AM_REG    = 3'd1,
    AM_DISP   = 3'd2,
    AM_IDX    = 3'd3,
    AM_SCALED = 3'd4,
    AM_PCREL  = 3'd5,
    AM_RSV6   = 3'd6,
    AM_RSV7   = 3'd7
  } addr_mode_e;

  typedef enum logic [1:0] {
    DW_8  = 2'd0,
    DW_16 = 2'd1,
    DW_32 = 2'd2,
    DW_32B = 2'd3
  } disp_width_e;

  localparam int MODE_W = 3;
  localparam int DCODE_W = 2;

endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
  parameter int W = 32
) (
  input  logic [W-1:0]                disp_raw,
  input  logic [agu_pkg::DCODE_W-1:0] width_code,
  output logic [W-1:0]                disp_ext
);
  import agu_pkg::*;

  function automatic logic [W-1:0] sext8(input logic [W-1:0] d);
    return {{(W-8){d[7]}}, d[7:0]};
  endfunction

  function automatic logic [W-1:0] sext16(input logic [W-1:0] d);
    return {{(W-16){d[15]}}, d[15:0]};
  endfunction

  always_comb begin
    unique case (disp_width_e'(width_code))
      DW_8:    disp_ext = sext8(disp_raw);
      DW_16:   disp_ext = sext16(disp_raw);
      default: disp_ext = disp_raw;
    endcase
  end
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
  parameter int W       = 32,
  parameter int SCALE_W = 2
) (
  input  logic [W-1:0]       index_in,
  input  logic [SCALE_W-1:0] shift_code,
  output logic [W-1:0]       index_scaled
);
  localparam int NSHIFT = 1 << SCALE_W;

  logic [W-1:0] shifted [NSHIFT];

  genvar s;
  generate
    for (s = 0; s < NSHIFT; s++) begin : g_shift
      assign shifted[s] = index_in << s;
    end
  endgenerate

  assign index_scaled = shifted[shift_code];
endmodule

// File: rtl/agu_mode_sel.sv
module agu_mode_sel #(
  parameter int W = 32
) (
  input  logic [agu_pkg::MODE_W-1:0] mode,
  input  logic [W-1:0]               base,
  input  logic [W-1:0]               index_raw,
  input  logic [W-1:0]               index_scaled,
  input  logic [W-1:0]               pc,
  input  logic [W-1:0]               disp_ext,
  output logic [W-1:0]               term_anchor,
  output logic [W-1:0]               term_index,
  output logic [W-1:0]               term_offset,
  output logic [W-1:0]               addr_sum
);
  import agu_pkg::*;

  function automatic logic [W-1:0] add3(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    return a + b + c;
  endfunction

  always_comb begin
    term_anchor = base;
    term_index  = '0;
    term_offset = '0;
    unique case (addr_mode_e'(mode))
      AM_ABS: begin
        term_anchor = '0;
        term_offset = disp_ext;
      end
      AM_DISP:   term_offset = disp_ext;
      AM_IDX:    term_index  = index_raw;
      AM_SCALED: begin
        term_index  = index_scaled;
        term_offset = disp_ext;
      end
      AM_PCREL: begin
        term_anchor = pc;
        term_offset = disp_ext;
      end
      default: ;
    endcase
  end

  assign addr_sum = add3(term_anchor, term_index, term_offset);
endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk #(
  parameter int W     = 32,
  parameter int ASZ_W = 2
) (
  input  logic [W-1:0]     addr,
  input  logic [ASZ_W-1:0] size_code,
  output logic             misaligned
);
  localparam int MAXLOG = (1 << ASZ_W) - 1;

  logic [MAXLOG-1:0] bad_bit;

  genvar i;
  generate
    for (i = 0; i < MAXLOG; i++) begin : g_bit
      assign bad_bit[i] = addr[i] & (32'(size_code) > i);
    end
  endgenerate

  assign misaligned = |bad_bit;
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int W       = 32,
  parameter int SCALE_W = 2,
  parameter int ASZ_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [agu_pkg::MODE_W-1:0]  mode,
  input  logic [W-1:0]                base,
  input  logic [W-1:0]                index,
  input  logic [W-1:0]                pc,
  input  logic [W-1:0]                disp,
  input  logic [agu_pkg::DCODE_W-1:0] disp_sz,
  input  logic [SCALE_W-1:0]          scale,
  input  logic [ASZ_W-1:0]            acc_sz,
  output logic                        out_valid,
  output logic [W-1:0]                eff_addr,
  output logic                        misaligned
);
  logic [W-1:0] disp_x;
  logic [W-1:0] index_sc;
  logic [W-1:0] t_anchor;
  logic [W-1:0] t_index;
  logic [W-1:0] t_offset;
  logic [W-1:0] ea_next;
  logic         mis_next;

  agu_disp_ext #(.W(W)) u_disp (
    .disp_raw   (disp),
    .width_code (disp_sz),
    .disp_ext   (disp_x)
  );

  agu_index_scale #(.W(W), .SCALE_W(SCALE_W)) u_scale (
    .index_in     (index),
    .shift_code   (scale),
    .index_scaled (index_sc)
  );

  agu_mode_sel #(.W(W)) u_sel (
    .mode         (mode),
    .base         (base),
    .index_raw    (index),
    .index_scaled (index_sc),
    .pc           (pc),
    .disp_ext     (disp_x),
    .term_anchor  (t_anchor),
    .term_index   (t_index),
    .term_offset  (t_offset),
    .addr_sum     (ea_next)
  );

  agu_align_chk #(.W(W), .ASZ_W(ASZ_W)) u_align (
    .addr       (ea_next),
    .size_code  (acc_sz),
    .misaligned (mis_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      eff_addr   <= '0;
      misaligned <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_addr   <= ea_next;
        misaligned <= mis_next;
      end
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int W       = 32,
  parameter int ASZ_W   = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [agu_pkg::MODE_W-1:0]  mode,
  input logic [W-1:0]                base,
  input logic [W-1:0]                index,
  input logic [W-1:0]                disp,
  input logic [agu_pkg::DCODE_W-1:0] disp_sz,
  input logic [ASZ_W-1:0]            acc_sz,
  input logic                        out_valid,
  input logic [W-1:0]                eff_addr,
  input logic                        misaligned
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(eff_addr) && $stable(misaligned)));

  p_abs_byte_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd0 && disp_sz == 2'd0) |=>
      eff_addr == {{(W-8){$past(disp[7])}}, $past(disp[7:0])});

  p_reg_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd1) |=> eff_addr == $past(base));

  p_indexed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd3) |=> eff_addr == W'($past(base) + $past(index)));

  p_byte_never_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_sz == '0) |=> !misaligned);

  p_word_align_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_sz == ASZ_W'(2)) |=> misaligned == (eff_addr[1:0] != 2'b00));
endmodule

bind addr_gen_unit agu_checker #(.W(W), .ASZ_W(ASZ_W)) u_agu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .mode       (mode),
  .base       (base),
  .index      (index),
  .disp       (disp),
  .disp_sz    (disp_sz),
  .acc_sz     (acc_sz),
  .out_valid  (out_valid),
  .eff_addr   (eff_addr),
  .misaligned (misaligned)
);

// File: tb/addr_gen_unit_tb_top.sv
module addr_gen_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base = '0, index = '0, pc = '0, disp = '0;
  logic [1:0]  disp_sz = '0, scale = '0, acc_sz = '0;
  logic        out_valid;
  logic [31:0] eff_addr;
  logic        misaligned;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] ea;
    logic        mis;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  logic [31:0] last_ea = '0;
  logic        last_mis = 1'b0;

  always #2 clk = ~clk;

  addr_gen_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .base(base), .index(index), .pc(pc), .disp(disp), .disp_sz(disp_sz),
    .scale(scale), .acc_sz(acc_sz), .out_valid(out_valid),
    .eff_addr(eff_addr), .misaligned(misaligned)
  );

  function automatic logic [31:0] ref_disp(input logic [31:0] d, input logic [1:0] c);
    int v;
    if (c == 2'd0)      v = int'($signed(d[7:0]));
    else if (c == 2'd1) v = int'($signed(d[15:0]));
    else                v = int'(d);
    return 32'(v);
  endfunction

  function automatic logic [31:0] ref_ea(input logic [2:0] m, input logic [31:0] b,
      input logic [31:0] x, input logic [31:0] p, input logic [31:0] d,
      input logic [1:0] dc, input logic [1:0] sc);
    longint unsigned acc;
    logic [31:0] dx;
    dx = ref_disp(d, dc);
    case (m)
      3'd0: acc = dx;
      3'd2: acc = longint'(b) + dx;
      3'd3: acc = longint'(b) + x;
      3'd4: acc = longint'(b) + longint'(x) * (64'd1 << sc) + dx;
      3'd5: acc = longint'(p) + dx;
      default: acc = b;
    endcase
    return acc[31:0];
  endfunction

  function automatic logic ref_mis(input logic [31:0] a, input logic [1:0] asz);
    return (a % (32'd1 << asz)) != 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [2:0] m, input logic [31:0] b,
      input logic [31:0] x, input logic [31:0] p, input logic [31:0] d,
      input logic [1:0] dc, input logic [1:0] sc, input logic [1:0] asz);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; mode = m; base = b; index = x; pc = p; disp = d;
    disp_sz = dc; scale = sc; acc_sz = asz;
    e.ea  = ref_ea(m, b, x, p, d, dc, sc);
    e.mis = ref_mis(e.ea, asz);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      base = base ^ 32'h5A5A_0F0F; index = ~index; disp = disp + 32'd3;
      mode = mode + 3'd1; acc_sz = acc_sz + 2'd1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual=out_valid expected=no result pending");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " addr"}, eff_addr, e.ea);
        check({e.tag, " misaligned"}, {31'd0, misaligned}, {31'd0, e.mis});
        last_ea = e.ea;
        last_mis = e.mis;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset addr", eff_addr, 32'd0);
    check("R1 reset misaligned", {31'd0, misaligned}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release valid", {31'd0, out_valid}, 32'd0);
    check("R1 after release addr", eff_addr, 32'd0);

    // R4 / R5 displacement widths in absolute mode
    drive("R5 abs disp8 neg",   3'd0, 32'h1111_1111, 0, 0, 32'h0000_0080, 2'd0, 0, 0);
    drive("R4 disp8 upper bits ignored", 3'd0, 0, 0, 0, 32'hABCD_127F, 2'd0, 0, 0);
    drive("R4 disp16 neg",      3'd0, 0, 0, 0, 32'h1234_8000, 2'd1, 0, 0);
    drive("R4 disp16 pos",      3'd0, 0, 0, 0, 32'hFFFF_7FFE, 2'd1, 0, 1);
    drive("R4 disp32 code2",    3'd0, 0, 0, 0, 32'h8000_0004, 2'd2, 0, 2);
    drive("R4 disp32 code3",    3'd0, 0, 0, 0, 32'h7654_3210, 2'd3, 0, 3);
    // R6 / R7 / R8 / R10 / R11
    drive("R6 register",        3'd1, 32'hDEAD_BEE8, 32'h99, 32'h44, 32'h77, 2'd2, 2'd3, 2'd3);
    drive("R7 base disp neg",   3'd2, 32'h0000_1000, 0, 0, 32'h0000_00F0, 2'd0, 0, 2);
    drive("R7 base disp16",     3'd2, 32'h0001_0000, 0, 0, 32'h0000_1234, 2'd1, 0, 1);
    drive("R8 indexed",         3'd3, 32'h0000_1000, 32'h0000_0024, 0, 32'h0000_0100, 2'd2, 2'd3, 2'd2);
    drive("R10 pc relative",    3'd5, 32'hFFFF_0000, 0, 32'h0040_0000, 32'h0000_FFFC, 2'd1, 0, 2);
    drive("R11 reserved mode6", 3'd6, 32'h0000_2002, 32'h5, 32'h9, 32'h40, 2'd2, 2'd1, 1);
    drive("R11 reserved mode7", 3'd7, 32'h0000_3003, 32'h5, 32'h9, 32'h40, 2'd2, 2'd1, 0);
    // R9 all scale codes
    for (int s = 0; s < 4; s++)
      drive("R9 scaled", 3'd4, 32'h0000_8000, 32'h0000_0013, 0, 32'h0000_00FF, 2'd0, 2'(s), 0);
    drive("R9 scaled big index", 3'd4, 32'h1000_0000, 32'h4000_0001, 0, 32'h10, 2'd2, 2'd3, 3);
    // R12 wrap
    drive("R12 wrap disp",      3'd2, 32'hFFFF_FFF0, 0, 0, 32'h0000_0020, 2'd2, 0, 2);
    drive("R12 wrap pc",        3'd5, 0, 0, 32'h0000_0004, 32'h0000_00F8, 2'd0, 0, 0);
    // R13 alignment sweep
    for (int a = 0; a < 8; a++)
      for (int z = 0; z < 4; z++)
        drive("R13 align", 3'd1, 32'h0000_1000 + 32'(a), 0, 0, 0, 2'd2, 0, 2'(z));
    // R3 hold while idle
    drive("R3 setup", 3'd2, 32'h0000_0101, 0, 0, 32'h0000_0002, 2'd2, 0, 2);
    idle(4);
    check("R2 idle valid low", {31'd0, out_valid}, 32'd0);
    check("R3 idle addr held", eff_addr, last_ea);
    check("R3 idle misaligned held", {31'd0, misaligned}, {31'd0, last_mis});
    // R2 back-to-back after idle
    drive("R2 b2b a", 3'd3, 32'h10, 32'h20, 0, 0, 2'd2, 0, 0);
    drive("R2 b2b b", 3'd3, 32'h30, 32'h40, 0, 0, 2'd2, 0, 1);
    idle(3);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual=%0d pending expected=0 pending", sb_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule